// File: doc/BRIEF.md
# CAN Controller Register Access Gate

This block holds the control segment of a memory-mapped CAN controller. It keeps a single reset-request bit that puts the controller in either reset mode or operating mode. It also keeps five configuration registers: acceptance code, acceptance mask, bus timing 0, bus timing 1 and output control. The host reaches all of them through a synchronous, RAM-like parallel port made of a chip select, write and read strobes, an address and a data bus. Host accesses do not depend on any CAN bus activity.

The configuration registers can only be changed while the controller is in reset mode. In operating mode the block drops writes to them without any indication, and reads of them return all ones. Two things force reset mode without the host: a hardware reset, and the bus-off indication from the protocol engine. The host can leave reset mode and enter it again at any time by writing the control register. The current mode and all five configuration values go out to the rest of the controller. While the controller is operating, the configuration values cannot change.

Top module: `cgate_top`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `op_mode` is 0, every configuration output is 0x00, and a read of address 0 returns 0x01.
- R2: A write to address 0 loads bit 0 of the data into the reset-request bit at that clock edge. Bit 0 = 0 gives `op_mode` = 1 from the next cycle on, and bit 0 = 1 gives `op_mode` = 0.
- R3: A cycle in which `bus_off` is high sets the reset-request bit, so `op_mode` is 0 in the following cycle. The bit stays set as long as `bus_off` stays high.
- R4: If `bus_off` is high in the same cycle as a host write of 0 to bit 0 of address 0, the bus-off event wins and the block stays in reset mode.
- R5: In reset mode, a write to address 4, 5, 6, 7 or 8 loads acceptance code, acceptance mask, bus timing 0, bus timing 1 or output control respectively. The new value appears on the matching output port one cycle later and is read back unchanged.
- R6: In operating mode, writes to addresses 4 to 8 have no effect on any configuration output or on the value read back after the block returns to reset mode.
- R7: In operating mode, a read of any of the addresses 4 to 8 returns 0xFF.
- R8: A read of address 0 returns the reset-request bit in bit 0 and zeros in bits 7 to 1. Reads of every other unmapped address return 0x00. Writes to unmapped addresses change neither the mode nor any configuration register.
- R9: `host_rdata` is 0x00 in every cycle in which `host_cs` or `host_rd` is low.
- R10: While `op_mode` is 1, the configuration outputs keep their values from one cycle to the next.
- R11: Whether a configuration write is accepted depends on the mode held before the clock edge. A configuration write in the same cycle as a `bus_off` assertion during operating mode is dropped.
- R12: A write strobe with `host_cs` low changes neither the mode nor any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| host_cs | input | 1 | Host chip select |
| host_wr | input | 1 | Host write strobe, sampled at the clock edge |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 5 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational from address and state |
| bus_off | input | 1 | Bus-off indication from the protocol engine |
| op_mode | output | 1 | 1 = operating mode, 0 = reset mode |
| cfg_code | output | 8 | Acceptance code |
| cfg_mask | output | 8 | Acceptance mask |
| cfg_tim0 | output | 8 | Bus timing 0 |
| cfg_tim1 | output | 8 | Bus timing 1 |
| cfg_outc | output | 8 | Output control |

## Verification
Two events can land on the same clock edge: a hardware bus-off, and a host write that either clears reset-request or targets a configuration register. The bench drives `bus_off` in the same cycle as a host write of 0 to the control register, both for a single cycle and for several cycles in a row. It then judges the result from `op_mode` in the next cycle. In a second case it pairs a bus-off with a configuration write during operating mode. After returning to reset mode it reads that register back and requires the value from before the write. Around these cases the bench sweeps every data value through every configuration register, and every address in both modes.

// File: rtl/cgate_pkg.sv
package cgate_pkg;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 8;
    localparam int NUM_CFG   = 5;
    localparam int CTRL_ADDR = 0;
    localparam int CFG_BASE  = 4;

    typedef enum logic {
        MODE_RESET = 1'b0,
        MODE_OPER  = 1'b1
    } mode_e;
endpackage

// File: rtl/cgate_decode.sv
module cgate_decode #(
    parameter int ADDR_W    = cgate_pkg::ADDR_W,
    parameter int NUM_CFG   = cgate_pkg::NUM_CFG,
    parameter int CTRL_ADDR = cgate_pkg::CTRL_ADDR,
    parameter int CFG_BASE  = cgate_pkg::CFG_BASE
) (
    input  logic               cs,
    input  logic               wr,
    input  logic               rd,
    input  logic [ADDR_W-1:0]  addr,
    output logic               ctrl_hit,
    output logic [NUM_CFG-1:0] cfg_hit,
    output logic               ctrl_wr,
    output logic [NUM_CFG-1:0] cfg_wr,
    output logic               rd_en
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    assign ctrl_hit = (addr == CTRL_A);
    assign ctrl_wr  = cs & wr & ctrl_hit;
    assign rd_en    = cs & rd;

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg_dec
        localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(CFG_BASE + g);
        assign cfg_hit[g] = (addr == SLOT_A);
        assign cfg_wr[g]  = cs & wr & cfg_hit[g];
    end
endmodule

// File: rtl/cgate_mode.sv
module cgate_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic req_bit,
    input  logic bus_off,
    output logic rst_req
);
    typedef struct packed {
        logic rst_req;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            st_d.rst_req = req_bit;
        end
        if (bus_off) begin
            st_d.rst_req = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{rst_req: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_req = st_q.rst_req;

    AST_BUSOFF_SETS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_off |=> rst_req); // R3

    AST_REQ_FALLS_BY_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req) |-> $past(ctrl_wr && !req_bit && !bus_off)); // R4
endmodule

// File: rtl/cgate_bank.sv
module cgate_bank #(
    parameter int NUM_CFG = cgate_pkg::NUM_CFG,
    parameter int DATA_W  = cgate_pkg::DATA_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_CFG-1:0]              cfg_wr,
    input  logic [DATA_W-1:0]               wdata,
    input  logic                            rst_req,
    output logic [NUM_CFG-1:0][DATA_W-1:0]  cfg_val
);
    typedef struct packed {
        logic [NUM_CFG-1:0][DATA_W-1:0] regs;
    } bank_st_t;

    bank_st_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_CFG; i++) begin
            if (cfg_wr[i] && rst_req) begin
                bank_d.regs[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign cfg_val = bank_q.regs;

    AST_CFG_FROZEN_OPER: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_req |=> $stable(cfg_val)); // R10

    AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cfg_wr)); // R8
endmodule

// File: rtl/cgate_rdmux.sv
module cgate_rdmux #(
    parameter int NUM_CFG = cgate_pkg::NUM_CFG,
    parameter int DATA_W  = cgate_pkg::DATA_W
) (
    input  logic                            rd_en,
    input  logic                            ctrl_hit,
    input  logic [NUM_CFG-1:0]              cfg_hit,
    input  logic                            rst_req,
    input  logic [NUM_CFG-1:0][DATA_W-1:0]  cfg_val,
    output logic [DATA_W-1:0]               rdata
);
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (ctrl_hit) begin
                rdata = {{(DATA_W-1){1'b0}}, rst_req};
            end
            for (int i = 0; i < NUM_CFG; i++) begin
                if (cfg_hit[i]) begin
                    rdata = rst_req ? cfg_val[i] : '1;
                end
            end
        end
    end
endmodule

// File: rtl/cgate_top.sv
module cgate_top
    import cgate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              bus_off,
    output logic              op_mode,
    output logic [DATA_W-1:0] cfg_code,
    output logic [DATA_W-1:0] cfg_mask,
    output logic [DATA_W-1:0] cfg_tim0,
    output logic [DATA_W-1:0] cfg_tim1,
    output logic [DATA_W-1:0] cfg_outc
);
    localparam logic [ADDR_W-1:0] CFG_LO = ADDR_W'(CFG_BASE);
    localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'(CFG_BASE + NUM_CFG - 1);

    logic                            ctrl_hit, ctrl_wr, rd_en, rst_req;
    logic [NUM_CFG-1:0]              cfg_hit, cfg_wr;
    logic [NUM_CFG-1:0][DATA_W-1:0]  cfg_val;
    mode_e                           mode;

    cgate_decode #(
        .ADDR_W(ADDR_W), .NUM_CFG(NUM_CFG),
        .CTRL_ADDR(CTRL_ADDR), .CFG_BASE(CFG_BASE)
    ) u_dec (
        .cs(host_cs), .wr(host_wr), .rd(host_rd), .addr(host_addr),
        .ctrl_hit(ctrl_hit), .cfg_hit(cfg_hit),
        .ctrl_wr(ctrl_wr), .cfg_wr(cfg_wr), .rd_en(rd_en)
    );

    cgate_mode u_mode (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
        .req_bit(host_wdata[0]), .bus_off(bus_off), .rst_req(rst_req)
    );

    cgate_bank #(.NUM_CFG(NUM_CFG), .DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .wdata(host_wdata),
        .rst_req(rst_req), .cfg_val(cfg_val)
    );

    cgate_rdmux #(.NUM_CFG(NUM_CFG), .DATA_W(DATA_W)) u_rd (
        .rd_en(rd_en), .ctrl_hit(ctrl_hit), .cfg_hit(cfg_hit),
        .rst_req(rst_req), .cfg_val(cfg_val), .rdata(host_rdata)
    );

    assign mode     = rst_req ? MODE_RESET : MODE_OPER;
    assign op_mode  = (mode == MODE_OPER);
    assign cfg_code = cfg_val[0];
    assign cfg_mask = cfg_val[1];
    assign cfg_tim0 = cfg_val[2];
    assign cfg_tim1 = cfg_val[3];
    assign cfg_outc = cfg_val[4];

    AST_OPER_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && host_rd && op_mode && host_addr >= CFG_LO && host_addr <= CFG_HI)
        |-> (host_rdata == '1)); // R7

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_cs && host_rd) |-> (host_rdata == '0)); // R9

    AST_NO_CS_NO_MODE_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_cs && !bus_off) |=> $stable(op_mode)); // R12
endmodule

// File: tb/sim_cgate_top.sv
module sim_cgate_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cs = 1'b0, host_wr = 1'b0, host_rd = 1'b0, bus_off = 1'b0;
    logic [4:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata, cfg_code, cfg_mask, cfg_tim0, cfg_tim1, cfg_outc;
    logic       op_mode;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_cfg [5];
    logic [7:0] rv;

    always #10 clk = ~clk;

    cgate_top u0 (
        .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_wr(host_wr),
        .host_rd(host_rd), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .bus_off(bus_off), .op_mode(op_mode),
        .cfg_code(cfg_code), .cfg_mask(cfg_mask), .cfg_tim0(cfg_tim0),
        .cfg_tim1(cfg_tim1), .cfg_outc(cfg_outc)
    );

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h expected=%0h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] cfg_port(input int i);
        case (i)
            0: return cfg_code;
            1: return cfg_mask;
            2: return cfg_tim0;
            3: return cfg_tim1;
            default: return cfg_outc;
        endcase
    endfunction

    task automatic cyc(input logic cs, input logic wr, input logic rd,
                       input logic [4:0] a, input logic [7:0] d, input logic bo);
        @(negedge clk);
        host_cs = cs; host_wr = wr; host_rd = rd;
        host_addr = a; host_wdata = d; bus_off = bo;
        #1;
        rv = host_rdata;
        @(negedge clk);
        host_cs = 1'b0; host_wr = 1'b0; host_rd = 1'b0; bus_off = 1'b0;
        #1;
    endtask

    task automatic chk_all_cfg(input string req);
        for (int i = 0; i < 5; i++) chk(req, cfg_port(i), exp_cfg[i]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog got=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 5; i++) exp_cfg[i] = 8'h00;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", op_mode, 0);
        chk_all_cfg("R1");
        @(negedge clk); rst_n = 1'b1;
        cyc(1, 0, 1, 5'd0, 8'h00, 0);
        chk("R1", rv, 8'h01);
        chk("R1", op_mode, 0);

        // R5: every value through every configuration register
        for (int r = 0; r < 5; r++) begin
            for (int v = 0; v < 256; v++) begin
                cyc(1, 1, 0, 5'(4 + r), 8'(v), 0);
                exp_cfg[r] = 8'(v);
                chk("R5", cfg_port(r), v);
                cyc(1, 0, 1, 5'(4 + r), 8'h00, 0);
                chk("R5", rv, v);
            end
        end
        for (int r = 0; r < 5; r++) begin
            cyc(1, 1, 0, 5'(4 + r), 8'(8'h13 * (r + 1)), 0);
            exp_cfg[r] = 8'(8'h13 * (r + 1));
        end
        chk_all_cfg("R5");

        // R8 and R12 in reset mode
        for (int a = 1; a < 32; a++) begin
            if (a >= 4 && a <= 8) continue;
            cyc(1, 1, 0, 5'(a), 8'h00, 0);
            chk("R8", op_mode, 0);
            cyc(1, 0, 1, 5'(a), 8'h00, 0);
            chk("R8", rv, 0);
        end
        cyc(0, 1, 0, 5'd4, 8'hEE, 0);
        chk("R12", cfg_code, exp_cfg[0]);
        cyc(0, 1, 0, 5'd0, 8'h00, 0);
        chk("R12", op_mode, 0);
        chk_all_cfg("R8");

        // R2: enter operating mode
        cyc(1, 1, 0, 5'd0, 8'hFE, 0);
        chk("R2", op_mode, 1);
        cyc(1, 0, 1, 5'd0, 8'h00, 0);
        chk("R8", rv, 8'h00);

        // R6, R7, R8 sweep in operating mode
        for (int a = 1; a < 32; a++) begin
            cyc(1, 1, 0, 5'(a), 8'(8'h5A ^ a), 0);
            chk("R6", op_mode, 1);
            chk_all_cfg("R6");
            cyc(1, 0, 1, 5'(a), 8'h00, 0);
            if (a >= 4 && a <= 8) chk("R7", rv, 8'hFF);
            else chk("R8", rv, 8'h00);
        end
        cyc(0, 0, 1, 5'd4, 8'h00, 0);
        chk("R9", rv, 0);
        cyc(1, 0, 0, 5'd4, 8'h00, 0);
        chk("R9", rv, 0);
        cyc(0, 1, 0, 5'd0, 8'h01, 0);
        chk("R12", op_mode, 1);

        // R11 and R3: bus-off together with a configuration write
        cyc(1, 1, 0, 5'd5, 8'h77, 1);
        chk("R3", op_mode, 0);
        chk("R11", cfg_mask, exp_cfg[1]);
        for (int r = 0; r < 5; r++) begin
            cyc(1, 0, 1, 5'(4 + r), 8'h00, 0);
            chk("R6", rv, exp_cfg[r]);
        end

        // R4: bus-off wins over a host clear in the same cycle
        cyc(1, 1, 0, 5'd0, 8'h00, 0);
        chk("R2", op_mode, 1);
        cyc(1, 1, 0, 5'd0, 8'h00, 1);
        chk("R4", op_mode, 0);
        @(negedge clk);
        host_cs = 1; host_wr = 1; host_addr = 5'd0; host_wdata = 8'h00; bus_off = 1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            chk("R4", op_mode, 0);
            chk("R3", op_mode, 0);
        end
        bus_off = 0;
        @(negedge clk); #1;
        host_cs = 0; host_wr = 0;
        chk("R2", op_mode, 1);
        cyc(1, 1, 0, 5'd0, 8'h01, 0);
        chk("R2", op_mode, 0);
        cyc(1, 1, 0, 5'd6, 8'h3C, 0);
        exp_cfg[2] = 8'h3C;
        chk("R5", cfg_tim0, 8'h3C);

        // R1: hardware reset mid-run
        cyc(1, 1, 0, 5'd0, 8'h00, 0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); #1;
        for (int i = 0; i < 5; i++) exp_cfg[i] = 8'h00;
        chk("R1", op_mode, 0);
        chk_all_cfg("R1");
        rst_n = 1'b1;
        cyc(1, 0, 1, 5'd0, 8'h00, 0);
        chk("R1", rv, 8'h01);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule